// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block carries out one complete serial flash transaction per start pulse. On start it captures an 8-bit opcode, a 24-bit address and an 8-bit length field. It then drives the chip select, serial clock and serial data-out lines, and samples serial data-in. The shape of the frame comes from the opcode value alone. A frame can be:

- the opcode only;
- the opcode followed by received data;
- the opcode followed by three address bytes;
- the opcode and address followed by transmitted or received data.

Outgoing payload bytes are fetched from an external byte-addressed buffer. Incoming bytes are written into the same buffer. Buffer index 0 holds the first payload byte on the wire.

The block is used behind a register front end. That front end fills the buffer, presents the opcode, address and length, and pulses `start`. It then waits for `done`, or watches `busy`. The block does not poll the flash status, does not enforce write-enable or protection rules, and does not check page boundaries.

Top module: `spi_flash_seq`

## Requirements
- R1: Opcodes 0x06, 0x04, 0xC7, 0xB9 and 0xAB, and every opcode not listed in R2 to R6, produce a frame of exactly 8 SCK cycles that carries only the opcode.
- R2: Opcodes 0x9F and 0x05 send the opcode and then receive LEN+1 bytes. There is no address. Received byte k is written to buffer index k.
- R3: Opcode 0x01 sends the opcode and then exactly one payload byte, taken from buffer index 0, whatever the value of LEN.
- R4: Opcodes 0xD8, 0x52, 0x20, 0x36 and 0x39 send the opcode and then the address as three bytes in the order bits 23:16, 15:8, 7:0. They have no data phase.
- R5: Opcodes 0x03 and 0x3C send the opcode and the three address bytes, then receive LEN+1 bytes into buffer indices 0 to LEN.
- R6: Opcode 0x02 sends the opcode and the three address bytes, then sends buffer bytes 0 to LEN in index order.
- R7: LEN = 0x00 moves one payload byte and LEN = 0xFF moves 256. A receive frame writes no buffer index above LEN.
- R8: SPI mode 0. SCK idles low. MOSI changes only on the falling edge and is stable while SCK is high. MISO is sampled on the rising edge. Every byte is sent and received MSB first.
- R9: SCK runs at the clock rate divided by CLK_DIV. CS_n falls exactly CLK_DIV clock cycles before the first rising SCK edge. It rises exactly CLK_DIV cycles after the last falling SCK edge. SCK stays low while CS_n is high.
- R10: `busy` is high from the cycle after an accepted start until the cycle in which CS_n rises. `done` pulses for one cycle in that same cycle.
- R11: A start pulse while `busy` is high is ignored. The running frame, the latched inputs and the count of frames are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame with the current opcode, address and length |
| opcode | input | 8 | Flash opcode; also selects the frame shape |
| flash_addr | input | 24 | Byte address for opcodes that take one |
| len_m1 | input | 8 | Payload length minus one |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when chip select releases |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| cs_n | output | 1 | Active-low chip select |
| buf_addr | output | 8 | Buffer byte index |
| buf_rdata | input | 8 | Buffer byte at `buf_addr`, read combinationally |
| buf_wdata | output | 8 | Received byte to store |
| buf_we | output | 1 | Store `buf_wdata` at `buf_addr` on this clock edge |

## Verification
A flash model drives a distinct value on every byte of the MISO stream and captures every MOSI bit on rising SCK. Each opcode class is run with its own LEN value, so that a wrong decode shows up as a wrong bit count or a misplaced byte. Opcode 0x01 is run with a large LEN to show that LEN is ignored there. LEN values of 0x00 and 0xFF tell an off-by-one in the length from a wrap of the 8-bit count. Sentinel bytes left above the received range show stray buffer writes. A start pulse in the middle of a frame carries a different opcode, so it is visible if it is taken.

// File: rtl/spi_seq_pkg.sv
// Shared types for the SPI flash command sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package spi_seq_pkg;
    typedef enum logic [1:0] {DIR_NONE, DIR_RD, DIR_WR} dir_e;

    typedef struct packed {
        logic has_addr;  // three address bytes follow the opcode
        dir_e dir;       // data phase direction
        logic one_byte;  // data phase is fixed at a single byte
    } frame_t;

    typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} state_e;
endpackage

// File: rtl/spi_op_decode.sv
// Maps an opcode to the shape of its frame.
// Assumes: unknown opcodes are sent as opcode-only frames.
module spi_op_decode
    import spi_seq_pkg::*;
(
    input  logic [7:0] op,
    output frame_t     frm
);
    // Purpose: opcode to frame-shape lookup.
    always_comb begin
        frm = '{has_addr: 1'b0, dir: DIR_NONE, one_byte: 1'b0};
        case (op)
            8'h9F, 8'h05:                      frm.dir = DIR_RD;
            8'h01: begin                       frm.dir = DIR_WR; frm.one_byte = 1'b1; end
            8'hD8, 8'h52, 8'h20, 8'h36, 8'h39: frm.has_addr = 1'b1;
            8'h03, 8'h3C: begin                frm.has_addr = 1'b1; frm.dir = DIR_RD; end
            8'h02: begin                       frm.has_addr = 1'b1; frm.dir = DIR_WR; end
            default:                           frm = frm;
        endcase
    end
endmodule

// File: rtl/spi_half_tick.sv
// Emits a one-cycle tick every HALF clock cycles while enabled.
// Assumes: HALF >= 1. The counter restarts from zero whenever it is disabled.
module spi_half_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == LAST);

    // Purpose: divide the clock down to half-SCK periods.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_flash_seq.sv
// Runs one SPI mode-0 flash transaction per start pulse: the opcode, then
// optional address bytes, then an optional data phase to or from a byte buffer.
// Assumes: CLK_DIV is even and >= 2; buf_rdata follows buf_addr in the same cycle.
module spi_flash_seq
    import spi_seq_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  opcode,
    input  logic [23:0] flash_addr,
    input  logic [7:0]  len_m1,
    output logic        busy,
    output logic        done,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n,
    output logic [7:0]  buf_addr,
    input  logic [7:0]  buf_rdata,
    output logic [7:0]  buf_wdata,
    output logic        buf_we
);
    localparam int HALF = CLK_DIV / 2;
    localparam int BW   = 9;  // byte index width: up to 4 + 256 bytes

    state_e      st;
    frame_t      frm_dec, frm_q;
    logic [7:0]  op_q, len_q;
    logic [23:0] addr_q;
    logic [7:0]  tx_sh, rx_sh;
    logic [2:0]  bit_cnt;
    logic [BW-1:0] byte_no, last_no, hdr, next_no, dlen;
    logic        tick, half_q, byte_end;
    logic [7:0]  next_byte;

    spi_op_decode u_dec (.op(opcode), .frm(frm_dec));

    spi_half_tick #(.HALF(HALF)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(st != ST_IDLE), .tick(tick)
    );

    // Purpose: frame geometry from the latched opcode shape and length.
    always_comb begin
        hdr = frm_q.has_addr ? BW'(4) : BW'(1);
        if (frm_q.dir == DIR_NONE) dlen = '0;
        else if (frm_q.one_byte)   dlen = BW'(1);
        else                       dlen = BW'(len_q) + BW'(1);
        last_no = hdr + dlen - BW'(1);
        next_no = byte_no + BW'(1);
    end

    // Purpose: buffer index (the next byte to send, or the byte being received) and the next byte to send.
    always_comb begin
        if (frm_q.dir == DIR_WR) buf_addr = 8'(next_no - hdr);
        else                     buf_addr = 8'(byte_no - hdr);
        case (next_no[1:0])
            2'd1:    next_byte = addr_q[23:16];
            2'd2:    next_byte = addr_q[15:8];
            default: next_byte = addr_q[7:0];
        endcase
        if (next_no >= hdr)
            next_byte = (frm_q.dir == DIR_WR) ? buf_rdata : 8'h00;
    end

    assign byte_end  = (st == ST_SHIFT) && tick && sck && (bit_cnt == 3'd7);
    assign buf_we    = byte_end && (frm_q.dir == DIR_RD) && (byte_no >= hdr);
    assign buf_wdata = rx_sh;
    assign mosi      = (st == ST_LEAD || st == ST_SHIFT) ? tx_sh[7] : 1'b0;

    // Purpose: frame sequencer, SCK generation and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cs_n    <= 1'b1;
            sck     <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            half_q  <= 1'b0;
            op_q    <= '0;
            len_q   <= '0;
            addr_q  <= '0;
            frm_q   <= '{has_addr: 1'b0, dir: DIR_NONE, one_byte: 1'b0};
            tx_sh   <= '0;
            rx_sh   <= '0;
            bit_cnt <= '0;
            byte_no <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    op_q    <= opcode;
                    len_q   <= len_m1;
                    addr_q  <= flash_addr;
                    frm_q   <= frm_dec;
                    tx_sh   <= opcode;
                    byte_no <= '0;
                    bit_cnt <= '0;
                    cs_n    <= 1'b0;
                    busy    <= 1'b1;
                    st      <= ST_LEAD;
                end
                ST_LEAD: if (tick) st <= ST_SHIFT;
                ST_SHIFT: if (tick) begin
                    if (!sck) begin
                        sck   <= 1'b1;
                        rx_sh <= {rx_sh[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bit_cnt == 3'd7) begin
                            bit_cnt <= '0;
                            if (byte_no == last_no) begin
                                half_q <= 1'b0;
                                st     <= ST_TRAIL;
                            end else begin
                                byte_no <= next_no;
                                tx_sh   <= next_byte;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 3'd1;
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                        end
                    end
                end
                ST_TRAIL: if (tick) begin
                    if (half_q) begin
                        cs_n <= 1'b1;
                        busy <= 1'b0;
                        done <= 1'b1;
                        st   <= ST_IDLE;
                    end else begin
                        half_q <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R9: the serial clock is idle low whenever chip select is released.
    a_r9_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R8: MOSI holds while SCK stays high.
    a_r8_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    // R10: done lasts one cycle and coincides with chip select release.
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n) && !busy));

    // R11: the latched opcode and length do not change during a frame.
    a_r11_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(op_q) && $stable(len_q)));

    // R7: a received byte is never stored above the requested length.
    a_r7_store_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (buf_addr <= len_q));
endmodule

// File: tb/spi_flash_seq_bench.sv
module spi_flash_seq_bench;
    localparam int CLK_DIV = 4;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b0;
    logic [7:0] opcode = '0, len_m1 = '0;
    logic [23:0] flash_addr = '0;
    logic busy, done, sck, mosi, cs_n, buf_we;
    logic [7:0] buf_addr, buf_wdata, buf_rdata;

    int n_tests = 0, n_fail = 0;
    logic [7:0] mem [256];
    logic [7:0] cap [264];
    int bit_i = 0, cyc = 0, cs_fall_c = 0, cs_rise_c = 0, first_rise_c = -1, last_fall_c = 0;
    int done_cnt = 0, done_c = 0;
    logic prev_cs = 1'b1, prev_sck = 1'b0;

    always #4 clk = ~clk;

    spi_flash_seq #(.CLK_DIV(CLK_DIV)) u_spi_flash_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .flash_addr(flash_addr), .len_m1(len_m1), .busy(busy), .done(done),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .buf_addr(buf_addr),
        .buf_rdata(buf_rdata), .buf_wdata(buf_wdata), .buf_we(buf_we)
    );

    assign buf_rdata = mem[buf_addr];
    always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;

    function automatic logic [7:0] strm(int b);
        return 8'(b * 37 + 90);
    endfunction

    // Flash model: captures MOSI on rising SCK, shifts the MISO stream on falling SCK.
    always @(negedge clk) begin
        cyc++;
        if (prev_cs && !cs_n) begin
            bit_i = 0; cs_fall_c = cyc; first_rise_c = -1;
            miso = strm(0)[7];
        end
        if (!prev_sck && sck) begin
            if (first_rise_c < 0) first_rise_c = cyc;
            if (bit_i < 264 * 8) cap[bit_i / 8][7 - bit_i % 8] = mosi;
            bit_i++;
        end
        if (prev_sck && !sck) begin
            last_fall_c = cyc;
            miso = strm(bit_i / 8)[7 - bit_i % 8];
        end
        if (!prev_cs && cs_n) cs_rise_c = cyc;
        if (done) begin done_cnt++; done_c = cyc; end
        prev_cs = cs_n; prev_sck = sck;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] seed);
        for (int k = 0; k < 256; k++) mem[k] = 8'(k * 13) ^ seed;
    endtask

    task automatic kick(input logic [7:0] op, input logic [23:0] a, input logic [7:0] l);
        @(negedge clk);
        opcode = op; flash_addr = a; len_m1 = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10 busy after start", busy, 1);
    endtask

    // Runs one frame and checks bits, bytes, buffer and timing.
    task automatic frame(input logic [7:0] op, input logic [23:0] a, input logic [7:0] l,
                         input int hdr, input int dlen, input int dir, input string req);
        logic [7:0] snap [256];
        int d0;
        fill(op ^ 8'hA5);
        if (dir == 1) for (int k = 0; k < 256; k++) mem[k] = 8'hEE;
        for (int k = 0; k < 256; k++) snap[k] = mem[k];
        d0 = done_cnt;
        kick(op, a, l);
        while (done_cnt == d0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(bit_i == 8 * (hdr + dlen), {req, " bit count"}, bit_i, 8 * (hdr + dlen));
        chk(cap[0] == op, {req, " opcode byte"}, cap[0], op);
        if (hdr == 4) begin
            chk(cap[1] == a[23:16] && cap[2] == a[15:8] && cap[3] == a[7:0],
                {req, " R4 address order"}, {cap[1], cap[2], cap[3]}, a);
        end
        for (int k = 0; k < dlen; k++) begin
            if (dir == 2 && cap[hdr + k] != snap[k]) begin
                chk(0, {req, " R8 tx byte"}, cap[hdr + k], snap[k]); break;
            end
            if (dir == 1 && mem[k] != strm(hdr + k)) begin
                chk(0, {req, " R8 rx byte"}, mem[k], strm(hdr + k)); break;
            end
        end
        if (dir == 1 && dlen < 256) begin
            chk(mem[dlen] == 8'hEE, {req, " R7 no write past length"}, mem[dlen], 8'hEE);
        end
        chk(first_rise_c - cs_fall_c == CLK_DIV, "R9 lead time", first_rise_c - cs_fall_c, CLK_DIV);
        chk(cs_rise_c - last_fall_c == CLK_DIV, "R9 trail time", cs_rise_c - last_fall_c, CLK_DIV);
        chk(done_cnt == d0 + 1 && done_c == cs_rise_c, "R10 done with CS release", done_c, cs_rise_c);
        chk(busy == 1'b0, "R10 busy cleared", busy, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1 && sck == 1'b0, "R9 reset idle lines", {cs_n, sck}, 2'b10);
        chk(busy == 1'b0 && done == 1'b0, "R10 reset flags", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_start_while_busy();
        int d0 = done_cnt;
        fill(8'h3C);
        kick(8'h02, 24'h01_02_00, 8'h03);
        repeat (40) @(negedge clk);
        opcode = 8'h06; len_m1 = 8'h00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done_cnt == d0) @(negedge clk);
        repeat (60) @(negedge clk);
        chk(done_cnt == d0 + 1, "R11 one frame only", done_cnt - d0, 1);
        chk(bit_i == 8 * 8 && cap[0] == 8'h02, "R11 frame unchanged", bit_i, 64);
        chk(cs_n == 1'b1, "R11 no second frame", cs_n, 1);
    endtask

    initial begin
        #(200000 * 8);
        chk(0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        frame(8'h06, 24'h123456, 8'h44, 1, 0, 0, "R1 op-only 06");
        frame(8'hB9, 24'h000000, 8'h10, 1, 0, 0, "R1 op-only B9");
        frame(8'h77, 24'hFFFFFF, 8'h22, 1, 0, 0, "R1 unknown 77");
        frame(8'h9F, 24'h000000, 8'h03, 1, 4, 1, "R2 read id");
        frame(8'h05, 24'h000000, 8'h00, 1, 1, 1, "R2 R7 status len0");
        frame(8'h01, 24'h000000, 8'h05, 1, 1, 2, "R3 one byte");
        frame(8'hD8, 24'hA1B2C3, 8'h09, 4, 0, 0, "R4 erase");
        frame(8'h39, 24'h0F1E2D, 8'h00, 4, 0, 0, "R4 unprotect");
        frame(8'h3C, 24'h400000, 8'h00, 4, 1, 1, "R5 protect read");
        frame(8'h03, 24'h00ABCD, 8'h10, 4, 17, 1, "R5 read array");
        frame(8'h03, 24'h001234, 8'hFF, 4, 256, 1, "R5 R7 read 256");
        frame(8'h02, 24'h020300, 8'h09, 4, 10, 2, "R6 program");
        frame(8'h02, 24'h070000, 8'hFF, 4, 256, 2, "R6 R7 program 256");
        t_start_while_busy();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule